// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDR SDRAM from power-up to ready after a reset. It uses two configuration words that stay static: a timing word and a bank word. From them it works out the 8-bit payload for the mode-register write. It turns on the memory clock enable and holds refresh off. It waits a fixed power-up delay, then steps through one precharge, eight auto-refreshes and one mode-register set. A no-operation step follows every command, and each step is held for a minimum gap.

After the last step it drops the refresh-off override for one cycle and clears the mode payload, which restores normal operation. It then runs the whole pass a second time. When the second pass ends it raises a one-cycle done pulse and keeps a ready flag high. A downstream pin driver turns the 2-bit command code into RAS/CAS/WE levels.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, at the next clock edge every output goes to 0: `cmd`, `mode_data`, `ref_off`, `sd_en`, `done` and `ready`.
- R2: After reset is released, `sd_en` and `ref_off` are 1 and `cmd` is NOP. This lasts exactly DELAY_CYC = CLK_HZ/5000 cycles (200 us) before the first command appears.
- R3: Command codes are 0 = NOP, 1 = mode register set, 2 = auto refresh and 3 = precharge. One pass issues the 20-step order 3,0, then eight times 2,0, then 1,0.
- R4: Each of the 20 steps holds `cmd` for exactly GAP_CYC cycles (default 5). A command change is never closer than GAP_CYC cycles to the previous one.
- R5: The CAS latency is decoded from `timing_cfg[1:0]` and `timing_cfg[12]`. With bit 12 = 1, a field value of 0 means CL2. With bit 12 = 0, a field value of 1 means CL2. Every other combination means CL3. On a 32-bit bus, `mode_data` is 0x40 for CL2 and 0x60 for CL3.
- R6: When `bank_cfg[23]` is 0 (16-bit bus), the derived payload is halved: 0x20 for CL2 and 0x30 for CL3.
- R7: A nonzero `timing_cfg[23:16]` is passed to `mode_data` unchanged, overriding the derived value.
- R8: At the end of each pass there is one restore cycle in which `ref_off` = 0, `mode_data` = 0, `cmd` = NOP and `sd_en` = 1.
- R9: The full pass runs twice. The second pass repeats the delay with `ref_off` back at 1, followed by the same command order.
- R10: After the second restore cycle, `done` is 1 for exactly one cycle while `ready` rises. After that, `ready` stays 1 and `ref_off`, `cmd` and `mode_data` stay 0.
- R11: Asserting `rst` in the middle of a run restarts the sequencer from the first delay of the first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_cfg | input | 32 | Static timing word: CAS field [1:0], speed bit [12], preset payload [23:16] |
| bank_cfg | input | 32 | Static bank word: bus width at bit [23] (1 = 32-bit) |
| cmd | output | 2 | Command code to the pin driver |
| mode_data | output | 8 | Mode-register payload while refresh is held off |
| ref_off | output | 1 | Refresh-disable override active |
| sd_en | output | 1 | SDRAM clock/controller enable |
| done | output | 1 | One-cycle pulse when both passes have finished |
| ready | output | 1 | High from the end of the second pass onward |

## Verification
The checker assumes that `timing_cfg` and `bank_cfg` do not change while the block is out of reset. Under that assumption, the payload stays fixed through every refresh-off window. The bench writes new configuration words only while `rst` is held high, and it releases reset on a falling clock edge, so the assertions never see a configuration change in mid-pass. A cycle-by-cycle model of the two passes, computed from DELAY_CYC and GAP_CYC, gives the expected outputs. The bench builds the design with a reduced CLK_HZ to keep the delay short.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_MRS = 2'd1,
    CMD_REF = 2'd2,
    CMD_PRE = 2'd3
  } sdi_cmd_e;

  typedef enum logic [1:0] {
    ST_DELAY   = 2'd0,
    ST_CMD     = 2'd1,
    ST_RESTORE = 2'd2,
    ST_DONE    = 2'd3
  } sdi_state_e;

  localparam int CAS_LSB    = 0;
  localparam int SPEED_BIT  = 12;
  localparam int PRESET_LSB = 16;
  localparam int WIDTH_BIT  = 23;

  localparam logic [7:0] MD_CL2_W32 = 8'h40;
  localparam logic [7:0] MD_CL3_W32 = 8'h60;
endpackage

// File: rtl/sdi_mode_calc.sv
module sdi_mode_calc
  import sdram_init_pkg::*;
(
  input  logic [31:0] timing_cfg,
  input  logic [31:0] bank_cfg,
  output logic [7:0]  md
);
  logic [1:0] cas_f;
  logic       fast;
  logic       is_cl2;
  logic [7:0] preset;
  logic [7:0] wide_val;

  always_comb begin
    cas_f    = timing_cfg[CAS_LSB +: 2];
    fast     = timing_cfg[SPEED_BIT];
    preset   = timing_cfg[PRESET_LSB +: 8];
    is_cl2   = fast ? (cas_f == 2'd0) : (cas_f == 2'd1);
    wide_val = is_cl2 ? MD_CL2_W32 : MD_CL3_W32;
    if (preset != 8'd0)
      md = preset;
    else if (bank_cfg[WIDTH_BIT])
      md = wide_val;
    else
      md = wide_val >> 1;
  end
endmodule

// File: rtl/sdi_cmd_table.sv
module sdi_cmd_table
  import sdram_init_pkg::*;
#(
  parameter int NUM_REF = 8,
  localparam int STEPS  = 2 * (NUM_REF + 2),
  localparam int SW     = $clog2(STEPS)
) (
  input  logic [SW-1:0] step,
  output logic [1:0]    code
);
  logic [SW-1:0] slot;

  always_comb begin
    slot = step >> 1;
    if (step[0])
      code = CMD_NOP;
    else if (slot == '0)
      code = CMD_PRE;
    else if (slot == SW'(NUM_REF + 1))
      code = CMD_MRS;
    else
      code = CMD_REF;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int GAP_CYC = 5,
  parameter int PASSES  = 2,
  parameter int NUM_REF = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] timing_cfg,
  input  logic [31:0] bank_cfg,
  output logic [1:0]  cmd,
  output logic [7:0]  mode_data,
  output logic        ref_off,
  output logic        sd_en,
  output logic        done,
  output logic        ready
);
  localparam int DELAY_CYC = CLK_HZ / 5000;
  localparam int CNT_MAX   = (DELAY_CYC > GAP_CYC) ? DELAY_CYC : GAP_CYC;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int STEPS     = 2 * (NUM_REF + 2);
  localparam int SW        = $clog2(STEPS);
  localparam int PW        = $clog2(PASSES + 1);

  sdi_state_e    st;
  logic [CW-1:0] cnt;
  logic [SW-1:0] step;
  logic [PW-1:0] pass;
  logic [7:0]    md;
  logic [1:0]    tbl_code;
  logic          hold_off;

  sdi_mode_calc u_mode (
    .timing_cfg (timing_cfg),
    .bank_cfg   (bank_cfg),
    .md         (md)
  );

  sdi_cmd_table #(.NUM_REF(NUM_REF)) u_tbl (
    .step (step),
    .code (tbl_code)
  );

  assign hold_off = (st == ST_DELAY) || (st == ST_CMD);

  // sequencing state
  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_DELAY;
      cnt  <= '0;
      step <= '0;
      pass <= '0;
    end else begin
      unique case (st)
        ST_DELAY: begin
          if (cnt == CW'(DELAY_CYC - 1)) begin
            cnt  <= '0;
            step <= '0;
            st   <= ST_CMD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CMD: begin
          if (cnt == CW'(GAP_CYC - 1)) begin
            cnt <= '0;
            if (step == SW'(STEPS - 1))
              st <= ST_RESTORE;
            else
              step <= step + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RESTORE: begin
          if (pass == PW'(PASSES - 1)) begin
            st <= ST_DONE;
          end else begin
            pass <= pass + 1'b1;
            st   <= ST_DELAY;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd       <= CMD_NOP;
      mode_data <= '0;
      ref_off   <= 1'b0;
      sd_en     <= 1'b0;
      done      <= 1'b0;
      ready     <= 1'b0;
    end else begin
      sd_en     <= 1'b1;
      ref_off   <= hold_off;
      mode_data <= hold_off ? md : 8'd0;
      cmd       <= (st == ST_CMD) ? tbl_code : CMD_NOP;
      ready     <= (st == ST_DONE);
      done      <= (st == ST_DONE) && !ready;
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int GAP_CYC = 5
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cmd,
  input logic [7:0] mode_data,
  input logic       ref_off,
  input logic       sd_en,
  input logic       done,
  input logic       ready
);
  localparam int HW = $clog2(GAP_CYC + 1);

  logic [1:0]    prev_cmd;
  logic [HW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cmd <= 2'd0;
      held     <= HW'(GAP_CYC);
    end else begin
      prev_cmd <= cmd;
      if (cmd != prev_cmd)
        held <= HW'(1);
      else if (held < HW'(GAP_CYC))
        held <= held + 1'b1;
    end
  end

  // R4
  cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != prev_cmd) |-> (held >= HW'(GAP_CYC)));

  // R3
  cmd_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != 2'd0) |-> (ref_off && sd_en));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ready ##1 !done));

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> (ready && !ref_off && cmd == 2'd0));

  // R8
  restore_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_off) |-> (mode_data == 8'd0 && cmd == 2'd0 && sd_en));

  // R5
  md_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_off && $past(ref_off)) |-> $stable(mode_data));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .mode_data (mode_data),
  .ref_off   (ref_off),
  .sd_en     (sd_en),
  .done      (done),
  .ready     (ready)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
  localparam int CLK_HZ = 500_000;
  localparam int GAP    = 5;
  localparam int D      = CLK_HZ / 5000;
  localparam int NSTEP  = 20;
  localparam int L      = D + NSTEP * GAP + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] timing_cfg = 32'h0000_1000;
  logic [31:0] bank_cfg   = 32'h0080_0000;
  logic [1:0]  cmd;
  logic [7:0]  mode_data;
  logic        ref_off, sd_en, done, ready;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.CLK_HZ(CLK_HZ), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst(rst), .timing_cfg(timing_cfg), .bank_cfg(bank_cfg),
    .cmd(cmd), .mode_data(mode_data), .ref_off(ref_off), .sd_en(sd_en),
    .done(done), .ready(ready)
  );

  // {timing_cfg, bank_cfg, expected payload, kind: 0=CL decode 1=width 2=preset}
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {32'h0000_1000, 32'h0080_0000, 8'h40, 2'd0}, // R5 fast, field 0 -> CL2
    {32'h0000_1001, 32'h0080_0000, 8'h60, 2'd0}, // R5 fast, field 1 -> CL3
    {32'h0000_0001, 32'h0080_0000, 8'h40, 2'd0}, // R5 slow, field 1 -> CL2
    {32'h0000_0000, 32'h0080_0000, 8'h60, 2'd0}, // R5 slow, field 0 -> CL3
    {32'h0000_1002, 32'h0080_0000, 8'h60, 2'd0}, // R5 fast, field 2 -> CL3
    {32'h0000_0003, 32'h0000_0000, 8'h30, 2'd1}, // R6 16-bit CL3
    {32'h0000_1000, 32'h0000_0000, 8'h20, 2'd1}, // R6 16-bit CL2 fast
    {32'h0000_0001, 32'h0000_0000, 8'h20, 2'd1}, // R6 16-bit CL2 slow
    {32'h00A5_1002, 32'h0000_0000, 8'hA5, 2'd2}, // R7 preset beats derived
    {32'h0001_0000, 32'h0080_0000, 8'h01, 2'd2}  // R7 smallest preset
  };

  function automatic string kind_tag(input logic [1:0] k);
    case (k)
      2'd0:    return "R5";
      2'd1:    return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [1:0] step_code(input int st);
    if (st % 2 == 1) return 2'd0;
    if (st == 0) return 2'd3;
    if (st == NSTEP - 2) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared under reset
    check({cmd, mode_data, ref_off, sd_en, done, ready} == 14'd0, "R1",
          "outputs in reset", {18'd0, cmd, mode_data, ref_off, sd_en, done, ready}, 32'd0);
    rst = 1'b0;
  endtask

  // compare nsamp cycles against the two-pass model; reset released just before
  task automatic model_run(input int nsamp, input logic [7:0] md, input string tag);
    for (int k = 1; k <= nsamp; k++) begin
      int s, p, r;
      logic [1:0] e_cmd;
      logic [7:0] e_md;
      logic e_ref, e_done, e_rdy;
      string req;
      @(negedge clk);
      s = k - 1; p = s / L; r = s % L;
      e_done = 1'b0; e_rdy = 1'b0;
      if (p >= 2) begin
        e_cmd = 2'd0; e_md = 8'd0; e_ref = 1'b0; e_rdy = 1'b1;
        e_done = (s == 2 * L); req = "R10";
      end else if (r < D) begin
        e_cmd = 2'd0; e_md = md; e_ref = 1'b1;
        req = (p == 0) ? "R2" : "R9";
      end else if (r < D + NSTEP * GAP) begin
        e_cmd = step_code((r - D) / GAP); e_md = md; e_ref = 1'b1;
        req = (p == 0) ? "R3/R4" : "R9";
      end else begin
        e_cmd = 2'd0; e_md = 8'd0; e_ref = 1'b0; req = "R8";
      end
      check(cmd == e_cmd && mode_data == e_md && ref_off == e_ref && sd_en &&
            done == e_done && ready == e_rdy, {req, " ", tag},
            $sformatf("cycle %0d {cmd,md,ref,en,done,rdy}", s),
            {18'd0, cmd, mode_data, ref_off, sd_en, done, ready},
            {18'd0, e_cmd, e_md, e_ref, 1'b1, e_done, e_rdy});
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // table walk: payload decode (R5, R6, R7), set only while in reset
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst = 1'b1;
      timing_cfg = VEC[i][73:42];
      bank_cfg   = VEC[i][41:10];
      do_reset();
      repeat (3) @(negedge clk);
      check(mode_data == VEC[i][9:2] && ref_off && sd_en, kind_tag(VEC[i][1:0]),
            $sformatf("payload vector %0d", i), {24'd0, mode_data}, {24'd0, VEC[i][9:2]});
    end

    // R2/R3/R4/R8/R9/R10: two full passes, 32-bit CL2
    @(negedge clk); rst = 1'b1;
    timing_cfg = 32'h0000_1000; bank_cfg = 32'h0080_0000;
    do_reset();
    model_run(2 * L + 8, 8'h40, "full 32-bit");

    // R11: reset during the command phase restarts from the first delay
    @(negedge clk); rst = 1'b1;
    timing_cfg = 32'h0000_0003; bank_cfg = 32'h0000_0000;
    do_reset();
    model_run(D + 37, 8'h30, "pre-abort");
    do_reset();
    model_run(2 * L + 4, 8'h30, "R11 restart");

    // R10: ready holds long after completion
    repeat (20) @(negedge clk);
    check(ready && !done && !ref_off && cmd == 2'd0, "R10", "ready held",
          {28'd0, ready, done, ref_off, 1'b0}, 32'h8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule